// File: doc/BRIEF.md
# NAND Page Column Area Pointer

This block tracks which region of a 528-byte flash page a one-byte column address points into. A page is split into three regions. The low region covers bytes 0..255, the middle region covers 256..511, and the 16-byte spare region covers 512..527. The block watches the command bytes a host sends, qualified by a command strobe. Three of those command codes move the pointer between the regions.

The output is the full starting column. It is formed by joining the current region with the column byte, so no adder is needed. Selecting the low or spare region is sticky. Selecting the middle region lasts for one operation only, and then the pointer falls back to the low region.

The block also raises a one-cycle error pulse when a program is started in the middle region but the middle-region select was not the command sent just before the program command. It can sit in a host-side controller or inside a behavioural model of the flash device.

Top module: `nand_col_ptr`

## Requirements
- R1: After reset, `area` is 0 (low region, encoding 0 = low, 1 = middle, 2 = spare; 3 never appears), `progErr` is 0, and `effColumn` equals `colByte`.
- R2: Command 0x00 selects the low region. That selection survives program confirm (0x10), erase confirm (0xD0) and `readDone`.
- R3: Command 0x50 selects the spare region. That selection also survives 0x10, 0xD0 and `readDone`.
- R4: Command 0x01 selects the middle region for one operation. The next 0x10, 0xD0 or `readDone` pulse returns `area` to 0 on that clock edge.
- R5: Command 0xFF (reset) returns `area` to 0 from any region.
- R6: `effColumn` is combinational. It equals `colByte` in the low region and 256 + `colByte` in the middle region. In the spare region it equals 512 + `colByte[3:0]`, so the upper four bits of `colByte` are dropped.
- R7: Command 0x80 (program start) sent directly after 0x01 raises no error. The middle region then stays selected until the program confirm.
- R8: Command 0x80 sent while the middle region is selected, when the previous command was not 0x01, raises `progErr` for exactly the one cycle after the strobe edge.
- R9: Command 0x80 in the low or spare region never raises `progErr`, even when other commands were sent after the region was selected.
- R10: Any other command code (for example 0x70 or 0x90) leaves `area` unchanged.
- R11: `cmdByte` has no effect while `cmdValid` is low.
- R12: When a region-select command and `readDone` occur in the same cycle, the new selection wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Qualifies `cmdByte` as a command in this cycle |
| cmdByte | input | 8 | Command code |
| readDone | input | 1 | Pulses when a read operation's data phase ends |
| colByte | input | 8 | Column byte within the current region |
| area | output | 2 | Current region: 0 low, 1 middle, 2 spare |
| effColumn | output | 10 | Full starting column within the page |
| progErr | output | 1 | One-cycle pulse on an illegal middle-region program start |

## Verification
Assertions check the following on every cycle:
- the area encoding is legal;
- the spare region keeps its column in range;
- a spare select or a reset command lands on the right region one edge later;
- an end-of-operation event clears a one-shot selection;
- the area holds when no relevant strobe is present;
- every error pulse is caused by a program start in the middle region.

Some behaviours need ordered command histories, so only the bench's scenarios can show them:
- a sticky selection surviving several operations;
- the difference between 0x01 directly before 0x80 and 0x01 with an intervening command;
- the priority of a new select over a coincident `readDone`.

// File: rtl/nand_col_ptr_pkg.sv
`timescale 1ns/1ps
package nand_col_ptr_pkg;

  // Region encoding; the value doubles as the upper column bits.
  typedef enum logic [1:0] {
    AREA_LO    = 2'd0,
    AREA_MID   = 2'd1,
    AREA_SPARE = 2'd2
  } area_e;

  localparam logic [7:0] CMD_SEL_LO    = 8'h00;
  localparam logic [7:0] CMD_SEL_MID   = 8'h01;
  localparam logic [7:0] CMD_SEL_SPARE = 8'h50;
  localparam logic [7:0] CMD_PROG      = 8'h80;
  localparam logic [7:0] CMD_PROG_GO   = 8'h10;
  localparam logic [7:0] CMD_ERASE_GO  = 8'hD0;
  localparam logic [7:0] CMD_RESET     = 8'hFF;

  // Strobes handed from the decoder to the pointer datapath.
  typedef struct packed {
    logic selLo;
    logic selMid;
    logic selSpare;
    logic hardRst;
    logic opEnd;
    logic progStart;
    logic anyCmd;
  } ptr_ctrl_t;

endpackage

// File: rtl/nand_col_ptr_ctrl.sv
`timescale 1ns/1ps
module nand_col_ptr_ctrl
  import nand_col_ptr_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             readDone,
  output ptr_ctrl_t        ctrl
);

  logic [7:0] code;

  generate
    if (CMD_W >= 8) begin : g_wide
      assign code = cmdByte[7:0];
    end else begin : g_narrow
      assign code = {{(8-CMD_W){1'b0}}, cmdByte};
    end
  endgenerate

  always_comb begin
    ctrl           = '0;
    ctrl.anyCmd    = cmdValid;
    ctrl.selLo     = cmdValid && (code == CMD_SEL_LO);
    ctrl.selMid    = cmdValid && (code == CMD_SEL_MID);
    ctrl.selSpare  = cmdValid && (code == CMD_SEL_SPARE);
    ctrl.hardRst   = cmdValid && (code == CMD_RESET);
    ctrl.progStart = cmdValid && (code == CMD_PROG);
    // An operation ends on program confirm, erase confirm, or end of a read.
    ctrl.opEnd     = readDone ||
                     (cmdValid && ((code == CMD_PROG_GO) || (code == CMD_ERASE_GO)));
  end

endmodule

// File: rtl/nand_col_ptr_dp.sv
`timescale 1ns/1ps
module nand_col_ptr_dp
  import nand_col_ptr_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int SPARE_W = 4,
  localparam int OUT_W  = COL_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptr_ctrl_t        ctrl,
  input  logic [COL_W-1:0] colByte,
  output logic [1:0]       area,
  output logic [OUT_W-1:0] effColumn,
  output logic             progErr
);

  area_e            areaQ;
  logic             oneShotQ;   // middle region chosen for one operation
  logic             lastMidQ;   // previous command strobe was the middle select
  logic             errQ;
  logic [COL_W-1:0] colSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      areaQ    <= AREA_LO;
      oneShotQ <= 1'b0;
      lastMidQ <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      errQ <= ctrl.progStart && (areaQ == AREA_MID) && !lastMidQ;
      if (ctrl.anyCmd) lastMidQ <= ctrl.selMid;
      // A new selection takes priority over an end-of-operation event.
      if (ctrl.selLo) begin
        areaQ    <= AREA_LO;
        oneShotQ <= 1'b0;
      end else if (ctrl.selMid) begin
        areaQ    <= AREA_MID;
        oneShotQ <= 1'b1;
      end else if (ctrl.selSpare) begin
        areaQ    <= AREA_SPARE;
        oneShotQ <= 1'b0;
      end else if (ctrl.hardRst) begin
        areaQ    <= AREA_LO;
        oneShotQ <= 1'b0;
      end else if (ctrl.opEnd && oneShotQ) begin
        areaQ    <= AREA_LO;
        oneShotQ <= 1'b0;
      end
    end
  end

  // The spare region only decodes its low SPARE_W column bits.
  generate
    if (SPARE_W < COL_W) begin : g_mask
      always_comb begin
        colSel = colByte;
        if (areaQ == AREA_SPARE) colSel = {{(COL_W-SPARE_W){1'b0}}, colByte[SPARE_W-1:0]};
      end
    end else begin : g_full
      assign colSel = colByte;
    end
  endgenerate

  // The region code sits directly above the column bits, so no adder is needed.
  assign effColumn = {areaQ, colSel};
  assign area      = areaQ;
  assign progErr   = errQ;

  // Assertions
  p_area_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    area != 2'b11);

  p_sticky_spare_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.selSpare |=> area == AREA_SPARE);

  p_oneshot_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotQ && ctrl.opEnd && !ctrl.selLo && !ctrl.selMid && !ctrl.selSpare)
      |=> area == AREA_LO);

  p_reset_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.hardRst |=> area == AREA_LO);

  p_spare_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (area == AREA_SPARE) |-> (effColumn >= OUT_W'(512)) &&
                             (effColumn < OUT_W'(512 + (1 << SPARE_W))));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    progErr |-> $past(ctrl.progStart && area == AREA_MID));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.selLo || ctrl.selMid || ctrl.selSpare || ctrl.hardRst || ctrl.opEnd)
      |=> $stable(area));

endmodule

// File: rtl/nand_col_ptr.sv
`timescale 1ns/1ps
module nand_col_ptr
  import nand_col_ptr_pkg::*;
#(
  parameter int CMD_W   = 8,
  parameter int COL_W   = 8,
  parameter int SPARE_W = 4,
  localparam int OUT_W  = COL_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             readDone,
  input  logic [COL_W-1:0] colByte,
  output logic [1:0]       area,
  output logic [OUT_W-1:0] effColumn,
  output logic             progErr
);

  ptr_ctrl_t ctrl;

  nand_col_ptr_ctrl #(.CMD_W(CMD_W)) u_ctrl (
    .cmdValid (cmdValid),
    .cmdByte  (cmdByte),
    .readDone (readDone),
    .ctrl     (ctrl)
  );

  nand_col_ptr_dp #(.COL_W(COL_W), .SPARE_W(SPARE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .colByte   (colByte),
    .area      (area),
    .effColumn (effColumn),
    .progErr   (progErr)
  );

endmodule

// File: tb/test_nand_col_ptr.sv
`timescale 1ns/1ps
module test_nand_col_ptr;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdValid;
  logic [7:0] cmdByte;
  logic       readDone;
  logic [7:0] colByte;
  logic [1:0] area;
  logic [9:0] effColumn;
  logic       progErr;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nand_col_ptr i_nand_col_ptr (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .readDone(readDone), .colByte(colByte), .area(area),
    .effColumn(effColumn), .progErr(progErr)
  );

  // Vector layout: {valid, cmd, readDone, col, expArea, expCol, expErr, req}
  localparam int NV = 29;
  localparam logic [34:0] VEC [0:NV-1] = '{
    {1'b0, 8'h00, 1'b0, 8'h05, 2'd0, 10'd5,   1'b0, 4'd11}, // R11 idle
    {1'b1, 8'h01, 1'b0, 8'h10, 2'd1, 10'd272, 1'b0, 4'd4},  // R4 middle
    {1'b1, 8'h80, 1'b0, 8'h10, 2'd1, 10'd272, 1'b0, 4'd7},  // R7 legal
    {1'b0, 8'h00, 1'b0, 8'hFF, 2'd1, 10'd511, 1'b0, 4'd6},  // R6
    {1'b1, 8'h10, 1'b0, 8'h03, 2'd0, 10'd3,   1'b0, 4'd4},  // R4 revert
    {1'b1, 8'h50, 1'b0, 8'h3F, 2'd2, 10'd527, 1'b0, 4'd6},  // R6 spare mask
    {1'b1, 8'h10, 1'b0, 8'h02, 2'd2, 10'd514, 1'b0, 4'd3},  // R3
    {1'b0, 8'h00, 1'b1, 8'h02, 2'd2, 10'd514, 1'b0, 4'd3},  // R3
    {1'b1, 8'hD0, 1'b0, 8'h00, 2'd2, 10'd512, 1'b0, 4'd3},  // R3
    {1'b1, 8'h70, 1'b0, 8'h00, 2'd2, 10'd512, 1'b0, 4'd10}, // R10
    {1'b1, 8'h80, 1'b0, 8'h00, 2'd2, 10'd512, 1'b0, 4'd9},  // R9 spare
    {1'b1, 8'h01, 1'b0, 8'h00, 2'd1, 10'd256, 1'b0, 4'd4},  // R4
    {1'b1, 8'h70, 1'b0, 8'h00, 2'd1, 10'd256, 1'b0, 4'd10}, // R10
    {1'b1, 8'h80, 1'b0, 8'h00, 2'd1, 10'd256, 1'b1, 4'd8},  // R8 pulse
    {1'b0, 8'h00, 1'b0, 8'h00, 2'd1, 10'd256, 1'b0, 4'd8},  // R8 one cycle
    {1'b1, 8'hD0, 1'b0, 8'h00, 2'd0, 10'd0,   1'b0, 4'd4},  // R4 erase
    {1'b1, 8'h01, 1'b0, 8'h01, 2'd1, 10'd257, 1'b0, 4'd4},  // R4
    {1'b0, 8'h00, 1'b1, 8'h01, 2'd0, 10'd1,   1'b0, 4'd4},  // R4 read end
    {1'b1, 8'h00, 1'b0, 8'h80, 2'd0, 10'd128, 1'b0, 4'd2},  // R2
    {1'b1, 8'h10, 1'b0, 8'h80, 2'd0, 10'd128, 1'b0, 4'd2},  // R2
    {1'b1, 8'h50, 1'b0, 8'h20, 2'd2, 10'd512, 1'b0, 4'd6},  // R6
    {1'b1, 8'hFF, 1'b0, 8'h20, 2'd0, 10'd32,  1'b0, 4'd5},  // R5 from spare
    {1'b1, 8'h01, 1'b0, 8'h20, 2'd1, 10'd288, 1'b0, 4'd4},  // R4
    {1'b1, 8'hFF, 1'b0, 8'h20, 2'd0, 10'd32,  1'b0, 4'd5},  // R5 from middle
    {1'b0, 8'h50, 1'b0, 8'h20, 2'd0, 10'd32,  1'b0, 4'd11}, // R11 ignored
    {1'b1, 8'h01, 1'b1, 8'h00, 2'd1, 10'd256, 1'b0, 4'd12}, // R12
    {1'b1, 8'h90, 1'b0, 8'h00, 2'd1, 10'd256, 1'b0, 4'd10}, // R10
    {1'b1, 8'h80, 1'b0, 8'h00, 2'd1, 10'd256, 1'b1, 4'd8},  // R8
    {1'b1, 8'h10, 1'b0, 8'h00, 2'd0, 10'd0,   1'b0, 4'd4}   // R4
  };

  task automatic check(input string tag, input logic [1:0] ea,
                       input logic [9:0] ec, input logic ee);
    checks++;
    if (area !== ea || effColumn !== ec || progErr !== ee) begin
      errors++;
      $display("FAIL %s: area=%0d col=%0d err=%0b expected area=%0d col=%0d err=%0b",
               tag, area, effColumn, progErr, ea, ec, ee);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: expired, expected completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdByte = 8'h00; readDone = 1'b0; colByte = 8'h2A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 2'd0, 10'd42, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cmdValid = VEC[i][34];
      cmdByte  = VEC[i][33:26];
      readDone = VEC[i][25];
      colByte  = VEC[i][24:17];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i),
            VEC[i][16:15], VEC[i][14:5], VEC[i][4]);
    end

    // R1: reset from the spare region returns to the low region.
    cmdValid = 1'b1; cmdByte = 8'h50; colByte = 8'h07;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0;
    check("R3 spare before reset", 2'd2, 10'd519, 1'b0);
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 reset from spare", 2'd0, 10'd7, 1'b0);
    rstN = 1'b1;

    // R7: middle-region program keeps its region until confirm.
    cmdValid = 1'b1; cmdByte = 8'h01; colByte = 8'h00;
    @(posedge clk); @(negedge clk);
    cmdByte = 8'h80;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 region held during program", 2'd1, 10'd256, 1'b0);
    finish_run();
  end

endmodule